// File: doc/BRIEF.md
# Region Sharer Predictor

This block sits beside a private cache controller and guesses which remote core is likely to hold the data for a line that has just missed. It keeps a small fully-associative table. Each entry covers one aligned 1 KB block of memory and records the last two distinct remote cores that supplied data for any line in that block. When a miss hits a table entry, the block issues a direct request to the most recent supplier. In the same cycle it raises a notification to the home directory, so the directory remains the single point that orders coherence traffic. When a miss finds no entry, only an ordinary directory request goes out.

Every data response is fed back with its address and the identity of the responding core. The response refreshes or allocates the entry for its region, whether the data came straight from a predicted peer or through a directory forward. The requests are registered: they appear one clock after the miss is presented. The coherence state machine and the directory itself live elsewhere.

Top module: `sharer_predictor`

## Requirements
- R1: The region of an address is its bits [ADDR_W-1:10]; two addresses that differ only in bits [9:0] always get the same prediction.
- R2: A miss presented in cycle n gives `dir_valid`=1 in cycle n+1 with `req_addr` equal to the miss address. A cycle with no miss gives `dir_valid`=0 in the next cycle, with every other output also 0.
- R3: When a prediction exists, `direct_valid`=1, `dir_valid`=1 and `dir_notify`=1 are all asserted in the same cycle. `direct_valid` is never 1 without both of the others.
- R4: A miss whose region has no table entry gives `dir_valid`=1, `dir_notify`=0, `direct_valid`=0, and zeros on `direct_core`, `alt_valid` and `alt_core`.
- R5: On a predicted miss, `direct_core` is the most recent responder recorded for that region.
- R6: The responder sets the most recent sharer of its region entry, as follows:
  - A responder that differs from the current most recent one becomes most recent, and the previous most recent becomes second.
  - A responder equal to the current most recent one changes nothing.
  - The two recorded sharers are never equal.
  - The second sharer is reported on `alt_core`, with `alt_valid`=1, only on a predicted miss.
- R7: A response for a region not in the table allocates an entry. The slot is the lowest-numbered empty entry or, if all ENTRIES are full, the entry whose last response update is oldest. The new entry holds the responder as most recent and no second sharer.
- R8: A response whose responder equals LOCAL_CORE changes nothing: no entry, sharer or recency order is modified.
- R9: A miss presented in the same cycle as a response is predicted from the table as it stood before that response.
- R10: After reset every output is 0 and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_valid | input | 1 | A cache miss is presented this cycle |
| miss_addr | input | ADDR_W | Address of the missing line |
| rsp_valid | input | 1 | A data response arrived this cycle |
| rsp_addr | input | ADDR_W | Address of the responded line |
| rsp_core | input | CORE_W | Identity of the core that supplied the data |
| dir_valid | output | 1 | Request or notification to the home directory |
| dir_notify | output | 1 | 1: directory is told of a parallel direct request; 0: ordinary request |
| direct_valid | output | 1 | Direct request to a predicted core |
| direct_core | output | CORE_W | Target core of the direct request |
| alt_valid | output | 1 | A second sharer is known for the region |
| alt_core | output | CORE_W | Second most recent sharer |
| req_addr | output | ADDR_W | Miss address carried by both requests |

## Verification
The in-RTL assertions check on every cycle that the following hold:
- A direct request always travels with a directory notification, and a notification only with a direct request.
- Each miss leads to a directory request one cycle later carrying its address, and an idle cycle leads to none.
- No entry ever holds the same core twice.
- A response from the local core leaves the table untouched.

Only the bench's scenarios can show the remaining behaviour:
- Which core is predicted.
- The reordering of sharers after a response.
- Victim choice once the table is full.
- That a miss in the same cycle as a response sees the older table.

The bench checks these by comparing every output against a behavioural model on every cycle.

// File: rtl/sp_pkg.sv
package sp_pkg;
    // outcome of folding a responder into a sharer pair
    typedef enum logic [0:0] {
        MERGE_KEEP = 1'b0,
        MERGE_PUSH = 1'b1
    } merge_e;
endpackage

// File: rtl/sp_region_cam.sv
module sp_region_cam #(
    parameter int N     = 16,
    parameter int TAG_W = 22,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]            valid_i,
    input  logic [N-1:0][TAG_W-1:0] tags_i,
    input  logic [TAG_W-1:0]        tag_i,
    output logic                    hit_o,
    output logic [IDX_W-1:0]        idx_o
);
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (valid_i[i] && (tags_i[i] == tag_i)) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/sp_victim_pick.sv
module sp_victim_pick #(
    parameter int N = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]            valid_i,
    input  logic [N-1:0][IDX_W-1:0] age_i,
    output logic [IDX_W-1:0]        idx_o
);
    always_comb begin
        idx_o = '0;
        // oldest entry first, then any empty slot overrides it
        for (int i = N - 1; i >= 0; i--) begin
            if (age_i[i] == IDX_W'(N - 1)) idx_o = IDX_W'(i);
        end
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/sp_sharer_merge.sv
module sp_sharer_merge
    import sp_pkg::*;
#(
    parameter int CORE_W = 4
) (
    input  logic              has_i,
    input  logic [CORE_W-1:0] mru_i,
    input  logic              sec_v_i,
    input  logic [CORE_W-1:0] sec_i,
    input  logic [CORE_W-1:0] new_i,
    output logic [CORE_W-1:0] mru_o,
    output logic              sec_v_o,
    output logic [CORE_W-1:0] sec_o,
    output merge_e            kind_o
);
    always_comb begin
        if (has_i && (new_i == mru_i)) begin
            kind_o  = MERGE_KEEP;
            mru_o   = mru_i;
            sec_v_o = sec_v_i;
            sec_o   = sec_i;
        end else begin
            kind_o  = MERGE_PUSH;
            mru_o   = new_i;
            sec_v_o = has_i;
            sec_o   = has_i ? mru_i : '0;
        end
    end
endmodule

// File: rtl/sharer_predictor.sv
module sharer_predictor
    import sp_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CORE_W      = 4,
    parameter int ENTRIES     = 16,
    parameter int REGION_BITS = 10,
    parameter int LOCAL_CORE  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic              rsp_valid,
    input  logic [ADDR_W-1:0] rsp_addr,
    input  logic [CORE_W-1:0] rsp_core,
    output logic              dir_valid,
    output logic              dir_notify,
    output logic              direct_valid,
    output logic [CORE_W-1:0] direct_core,
    output logic              alt_valid,
    output logic [CORE_W-1:0] alt_core,
    output logic [ADDR_W-1:0] req_addr
);
    localparam int TAG_W = ADDR_W - REGION_BITS;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [CORE_W-1:0] mru;
        logic              sec_v;
        logic [CORE_W-1:0] sec;
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0]            tab;
        logic   [ENTRIES-1:0][IDX_W-1:0] age;
        logic                            dir_valid;
        logic                            dir_notify;
        logic                            direct_valid;
        logic   [CORE_W-1:0]             direct_core;
        logic                            alt_valid;
        logic   [CORE_W-1:0]             alt_core;
        logic   [ADDR_W-1:0]             req_addr;
    } state_t;

    state_t st_q, st_d;

    logic [ENTRIES-1:0]            ent_valid;
    logic [ENTRIES-1:0][TAG_W-1:0] ent_tag;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_view
        assign ent_valid[g] = st_q.tab[g].valid;
        assign ent_tag[g]   = st_q.tab[g].tag;
    end

    logic [TAG_W-1:0] miss_tag, rsp_tag;
    assign miss_tag = miss_addr[ADDR_W-1:REGION_BITS];
    assign rsp_tag  = rsp_addr[ADDR_W-1:REGION_BITS];

    logic             mhit, rhit;
    logic [IDX_W-1:0] midx, ridx, vidx, tgt;

    sp_region_cam #(.N(ENTRIES), .TAG_W(TAG_W)) u_miss_cam (
        .valid_i(ent_valid), .tags_i(ent_tag), .tag_i(miss_tag),
        .hit_o(mhit), .idx_o(midx)
    );

    sp_region_cam #(.N(ENTRIES), .TAG_W(TAG_W)) u_rsp_cam (
        .valid_i(ent_valid), .tags_i(ent_tag), .tag_i(rsp_tag),
        .hit_o(rhit), .idx_o(ridx)
    );

    sp_victim_pick #(.N(ENTRIES)) u_victim (
        .valid_i(ent_valid), .age_i(st_q.age), .idx_o(vidx)
    );

    assign tgt = rhit ? ridx : vidx;

    entry_t            cur;
    logic [CORE_W-1:0] m_mru, m_sec;
    logic              m_sec_v;
    merge_e            m_kind;

    assign cur = rhit ? st_q.tab[ridx] : '0;

    sp_sharer_merge #(.CORE_W(CORE_W)) u_merge (
        .has_i(cur.valid), .mru_i(cur.mru), .sec_v_i(cur.sec_v), .sec_i(cur.sec),
        .new_i(rsp_core),
        .mru_o(m_mru), .sec_v_o(m_sec_v), .sec_o(m_sec), .kind_o(m_kind)
    );

    logic take_rsp;
    assign take_rsp = rsp_valid && (rsp_core != CORE_W'(LOCAL_CORE));

    always_comb begin
        st_d              = st_q;
        st_d.dir_valid    = 1'b0;
        st_d.dir_notify   = 1'b0;
        st_d.direct_valid = 1'b0;
        st_d.direct_core  = '0;
        st_d.alt_valid    = 1'b0;
        st_d.alt_core     = '0;
        st_d.req_addr     = '0;

        // lookup sees the table before this cycle's response
        if (miss_valid) begin
            st_d.dir_valid = 1'b1;
            st_d.req_addr  = miss_addr;
            if (mhit) begin
                st_d.dir_notify   = 1'b1;
                st_d.direct_valid = 1'b1;
                st_d.direct_core  = st_q.tab[midx].mru;
                st_d.alt_valid    = st_q.tab[midx].sec_v;
                st_d.alt_core     = st_q.tab[midx].sec_v ? st_q.tab[midx].sec : '0;
            end
        end

        if (take_rsp) begin
            st_d.tab[tgt].valid = 1'b1;
            st_d.tab[tgt].tag   = rsp_tag;
            st_d.tab[tgt].mru   = m_mru;
            st_d.tab[tgt].sec_v = m_sec_v;
            st_d.tab[tgt].sec   = m_sec;
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == tgt)
                    st_d.age[i] = '0;
                else if (st_q.age[i] < st_q.age[tgt])
                    st_d.age[i] = st_q.age[i] + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < ENTRIES; i++) st_q.age[i] <= IDX_W'(i);
        end else begin
            st_q <= st_d;
        end
    end

    assign dir_valid    = st_q.dir_valid;
    assign dir_notify   = st_q.dir_notify;
    assign direct_valid = st_q.direct_valid;
    assign direct_core  = st_q.direct_core;
    assign alt_valid    = st_q.alt_valid;
    assign alt_core     = st_q.alt_core;
    assign req_addr     = st_q.req_addr;

    // R3: a direct request never leaves without the directory notice
    p_direct_has_notice_r3: assert property (@(posedge clk) disable iff (!rst_n)
        direct_valid |-> (dir_valid && dir_notify));

    // R4: a notice flag only accompanies a direct request
    p_notice_needs_direct_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dir_notify |-> direct_valid);

    // R2: every miss reaches the directory one cycle later with its address
    p_miss_to_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |=> (dir_valid && (req_addr == $past(miss_addr))));

    // R2: no request without a miss
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_valid |=> !dir_valid);

    // R8: responses from the local core leave the table alone
    p_local_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_core == CORE_W'(LOCAL_CORE))) |=> $stable(st_q.tab));

    for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
        // R6: the two recorded sharers are distinct
        p_no_dup_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.tab[g].valid && st_q.tab[g].sec_v) |-> (st_q.tab[g].sec != st_q.tab[g].mru));
    end
endmodule

// File: tb/sharer_predictor_tb_top.sv
module sharer_predictor_tb_top;
    localparam int AW = 32;
    localparam int CW = 4;
    localparam int NE = 16;
    localparam int LOCAL = 0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic [AW-1:0] miss_addr = '0;
    logic          rsp_valid = 1'b0;
    logic [AW-1:0] rsp_addr = '0;
    logic [CW-1:0] rsp_core = '0;
    logic          dir_valid, dir_notify, direct_valid, alt_valid;
    logic [CW-1:0] direct_core, alt_core;
    logic [AW-1:0] req_addr;

    always #4 clk = ~clk;  // 125 MHz

    sharer_predictor #(.ADDR_W(AW), .CORE_W(CW), .ENTRIES(NE), .REGION_BITS(10),
                       .LOCAL_CORE(LOCAL)) dut_i (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_core(rsp_core),
        .dir_valid(dir_valid), .dir_notify(dir_notify), .direct_valid(direct_valid),
        .direct_core(direct_core), .alt_valid(alt_valid), .alt_core(alt_core),
        .req_addr(req_addr)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural reference model
    bit      m_val [NE];
    int      m_tag [NE];
    int      m_mru [NE];
    int      m_sec [NE];
    bit      m_secv[NE];
    int      order[$];  // front = least recently updated
    bit      e_dv, e_dn, e_xv, e_av;
    int      e_xc, e_ac;
    logic [AW-1:0] e_addr;

    function automatic int region(logic [AW-1:0] a);
        return int'(a >> 10);  // R1: offset bits [9:0] dropped
    endfunction

    function automatic int find(int t);
        for (int i = 0; i < NE; i++) if (m_val[i] && m_tag[i] == t) return i;
        return -1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NE; i++) begin
                m_val[i] = 0; m_secv[i] = 0; m_tag[i] = 0; m_mru[i] = 0; m_sec[i] = 0;
            end
            order.delete();
            e_dv = 0; e_dn = 0; e_xv = 0; e_av = 0; e_xc = 0; e_ac = 0; e_addr = '0;
        end else begin
            int h, k;
            e_dv = 0; e_dn = 0; e_xv = 0; e_av = 0; e_xc = 0; e_ac = 0; e_addr = '0;
            // R9: predict from the table before this cycle's response
            if (miss_valid) begin
                e_dv = 1; e_addr = miss_addr;
                h = find(region(miss_addr));
                if (h >= 0) begin
                    e_dn = 1; e_xv = 1; e_xc = m_mru[h];
                    e_av = m_secv[h]; e_ac = m_secv[h] ? m_sec[h] : 0;
                end
            end
            if (rsp_valid && int'(rsp_core) != LOCAL) begin
                k = find(region(rsp_addr));
                if (k < 0) begin
                    k = -1;
                    for (int i = NE - 1; i >= 0; i--) if (!m_val[i]) k = i;
                    if (k < 0) k = order[0];
                    m_val[k] = 1; m_tag[k] = region(rsp_addr);
                    m_mru[k] = int'(rsp_core); m_secv[k] = 0; m_sec[k] = 0;
                end else if (m_mru[k] != int'(rsp_core)) begin
                    m_sec[k] = m_mru[k]; m_secv[k] = 1; m_mru[k] = int'(rsp_core);
                end
                for (int i = order.size() - 1; i >= 0; i--) if (order[i] == k) order.delete(i);
                order.push_back(k);
            end
        end
    end

    task automatic report(string tag, string what, longint act, longint exp);
        n_bad++;
        $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    endtask

    bit in_reset_check = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            n_cmp++;
            if (dir_valid !== e_dv)    report("R2", "dir_valid", dir_valid, e_dv);
            if (req_addr !== e_addr)   report("R2", "req_addr", req_addr, e_addr);
            if (dir_notify !== e_dn)   report("R3", "dir_notify", dir_notify, e_dn);
            if (direct_valid !== e_xv) report("R4", "direct_valid", direct_valid, e_xv);
            if (direct_core !== CW'(e_xc)) report("R5", "direct_core", direct_core, e_xc);
            if (alt_valid !== e_av)    report("R6", "alt_valid", alt_valid, e_av);
            if (alt_core !== CW'(e_ac))    report("R6", "alt_core", alt_core, e_ac);
        end
    end

    task automatic step(bit mv, logic [AW-1:0] ma, bit rv, logic [AW-1:0] ra, int rc);
        @(negedge clk);
        miss_valid = mv; miss_addr = ma;
        rsp_valid = rv; rsp_addr = ra; rsp_core = CW'(rc);
    endtask

    task automatic idle();
        step(0, '0, 0, '0, 0);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog expired actual=%0d expected=0", 1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs zero during reset
        n_cmp++;
        if ({dir_valid, dir_notify, direct_valid, alt_valid, direct_core, alt_core, req_addr} !== '0)
            report("R10", "reset outputs", {direct_core, alt_core}, 0);
        rst_n = 1'b1;
        idle();
        // R4: empty table, directory only
        step(1, 32'h0000_1008, 0, '0, 0);
        // R7: allocate region 4 with core 3
        step(0, '0, 1, 32'h0000_1004, 3);
        // R1 R5: other offset of the same region predicts core 3
        step(1, 32'h0000_13FC, 0, '0, 0);
        // R6: new responder 5 pushes 3 to second
        step(0, '0, 1, 32'h0000_1200, 5);
        step(1, 32'h0000_1010, 0, '0, 0);
        // R6: 3 again swaps the order; repeat is a duplicate
        step(0, '0, 1, 32'h0000_1000, 3);
        step(1, 32'h0000_1020, 0, '0, 0);
        step(0, '0, 1, 32'h0000_1000, 3);
        step(1, 32'h0000_1020, 0, '0, 0);
        // R8: local core response ignored
        step(0, '0, 1, 32'h0000_1000, LOCAL);
        step(1, 32'h0000_1040, 0, '0, 0);
        // R9: same-cycle miss and response uses the older table
        step(1, 32'h0000_1080, 1, 32'h0000_1000, 7);
        step(1, 32'h0000_1080, 0, '0, 0);
        // R9: miss to a region being allocated in the same cycle still misses
        step(1, 32'h0000_8000, 1, 32'h0000_8004, 9);
        step(1, 32'h0000_8000, 0, '0, 0);
        // R7: fill the table and evict the least recently updated region
        for (int i = 0; i < 16; i++) step(0, '0, 1, AW'((100 + i) << 10), 2);
        step(1, 32'h0000_1000, 0, '0, 0);
        step(1, 32'h0000_8000, 0, '0, 0);
        step(1, AW'(115 << 10), 0, '0, 0);
        idle();
        // mixed traffic over a few more regions than entries
        for (int i = 0; i < 4000; i++) begin
            step($urandom_range(0, 1), AW'(($urandom_range(0, 19) << 10) | $urandom_range(0, 1023)),
                 $urandom_range(0, 1), AW'(($urandom_range(0, 19) << 10) | $urandom_range(0, 1023)),
                 $urandom_range(0, 15));
        end
        idle();
        idle();
        summary();
        $finish;
    end
endmodule